// File: doc/BRIEF.md
# I2C Master Byte-Count Sequencer

This block follows the byte count of an I2C master transfer and decides what happens when a programmed count is used up. Software supplies a byte count, a reload mode, an automatic-end mode, a request for a trailing PEC byte, and start and stop requests. The bus shift engine sends a strobe for each finished byte and a pulse when the address phase is over. The block answers with a completion flag, a reload-pending flag, a STOP request, a PEC-send request and hardware clearing of the start request.

A transfer is split into segments. In reload mode, the end of each segment raises the reload-pending flag and waits for a new count, so one transfer can be longer than one count allows. Outside reload mode, the end of the count either raises the completion flag and holds the bus for software, or sets the STOP request by itself. The choice depends on the automatic-end bit. The remaining count is shown on `bytes_left`.

Top module: `i2c_xfer_len_seq`

## Requirements
- R1: After reset, `start_req`, `stop_req`, `xfer_done`, `reload_pend` and `pec_send` are 0 and `bytes_left` is 0.
- R2: A `start_set` pulse sets `start_req`. It is cleared on the edge after `addr_done`, `arb_lost`, `timeout_err`, or `enable` low. The clear wins over a set in the same cycle.
- R3: A `stop_set` pulse sets `stop_req`. It is cleared on the edge after `stop_det` or `enable` low. The clear wins.
- R4: A `len_wr` is accepted only while `start_req` is 0, and the value is stored. On `addr_done`, `bytes_left` loads the stored count. While counting, each `byte_done` lowers it by one.
- R5: With reload and automatic end both off, the end of the count sets `xfer_done` on the next edge. `xfer_done` is cleared by `start_set` or by `enable` low.
- R6: With reload off and automatic end on, the end of the count sets `stop_req`, and `xfer_done` stays 0.
- R7: With reload on, the end of the count sets `reload_pend`, whatever the automatic-end bit holds. `stop_req` and `xfer_done` are not set. An accepted `len_wr` clears `reload_pend` and loads `bytes_left` with the new count.
- R8: `pec_send` is 1 while one byte is left in an active, non-pending count, provided `pec_req` is 1 and reload is off. It is never 1 while reload is on.
- R9: A count of zero ends the segment one cycle after the address phase. The end action happens on the second edge after `addr_done`.
- R10: While `cnt_ctrl_en` is 0, `byte_done` leaves `bytes_left` unchanged and no end action happens.
- R11: When `enable` goes low, every flag and request is cleared and counting stops. The stored count is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Peripheral enable |
| cnt_ctrl_en | input | 1 | Byte-count control enable |
| reload_mode | input | 1 | Segment end requests a reload |
| auto_end | input | 1 | Segment end issues STOP (reload off) |
| pec_req | input | 1 | Replace the last byte by a PEC byte |
| len_wr | input | 1 | Write strobe for the byte count |
| len_val | input | 8 | Byte count value |
| start_set | input | 1 | Software start request |
| stop_set | input | 1 | Software stop request |
| addr_done | input | 1 | Address phase finished |
| arb_lost | input | 1 | Arbitration lost |
| timeout_err | input | 1 | Timeout error |
| stop_det | input | 1 | STOP detected on the bus |
| byte_done | input | 1 | One data byte finished |
| start_req | output | 1 | Start request pending |
| stop_req | output | 1 | STOP request pending |
| xfer_done | output | 1 | Transfer complete, bus held |
| reload_pend | output | 1 | Segment done, waiting for a new count |
| pec_send | output | 1 | Send the PEC byte next |
| bytes_left | output | 8 | Bytes remaining in the segment |

## Verification
The hardest state to reach is a chain of reload segments in which a new count is written while the flag is pending. This state needs a count already loaded, a finished address phase, a cleared start request and the exact number of byte strobes. Directed sequences build it step by step. They also hit the zero-count path and the write that arrives while `start_req` is still 1. A long random phase then mixes short counts, mode changes, disables and bus errors. A behavioural model is compared against the outputs every cycle.

// File: rtl/i2c_len_pkg.sv
package i2c_len_pkg;
  typedef enum logic [1:0] {
    END_NONE   = 2'd0,
    END_RELOAD = 2'd1,
    END_STOP   = 2'd2,
    END_DONE   = 2'd3
  } seg_end_e;

  // Reload wins over automatic end; automatic end wins over completion.
  function automatic seg_end_e pick_end(input logic hit, input logic reload,
                                        input logic auto_stop);
    if (!hit)        return END_NONE;
    else if (reload) return END_RELOAD;
    else if (auto_stop) return END_STOP;
    else             return END_DONE;
  endfunction

  function automatic logic ends_transfer(input seg_end_e e);
    return (e == END_STOP) || (e == END_DONE);
  endfunction
endpackage

// File: rtl/i2c_len_counter.sv
module i2c_len_counter
  import i2c_len_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             ctrl_en,
  input  logic             addr_done,
  input  logic             len_accept,
  input  logic [LEN_W-1:0] len_val,
  input  logic             byte_done,
  input  logic             pend,
  input  seg_end_e         end_act,
  output logic             active,
  output logic [LEN_W-1:0] remain,
  output logic             seg_hit
);
  localparam logic [LEN_W-1:0] ONE  = LEN_W'(1);
  localparam logic [LEN_W-1:0] ZERO = '0;

  logic [LEN_W-1:0] len_q;
  logic             count_on;

  assign count_on = active && ctrl_en && !pend;
  assign seg_hit  = enable && count_on &&
                    ((byte_done && remain == ONE) || remain == ZERO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q  <= '0;
      active <= 1'b0;
      remain <= '0;
    end else begin
      if (len_accept) len_q <= len_val;
      if (!enable) begin
        active <= 1'b0;
        remain <= '0;
      end else if (addr_done) begin
        active <= 1'b1;
        remain <= len_q;
      end else if (len_accept && pend) begin
        remain <= len_val;
      end else begin
        if (count_on && byte_done && remain != ZERO) remain <= remain - ONE;
        if (ends_transfer(end_act)) active <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/i2c_len_flags.sv
module i2c_len_flags
  import i2c_len_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     enable,
  input  logic     start_set,
  input  logic     stop_set,
  input  logic     addr_done,
  input  logic     arb_lost,
  input  logic     timeout_err,
  input  logic     stop_det,
  input  logic     len_accept,
  input  seg_end_e end_act,
  output logic     start_req,
  output logic     stop_req,
  output logic     xfer_done,
  output logic     reload_pend
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_req   <= 1'b0;
      stop_req    <= 1'b0;
      xfer_done   <= 1'b0;
      reload_pend <= 1'b0;
    end else begin
      if (!enable || addr_done || arb_lost || timeout_err) start_req <= 1'b0;
      else if (start_set)                                   start_req <= 1'b1;

      if (!enable || stop_det)                     stop_req <= 1'b0;
      else if (stop_set || end_act == END_STOP)    stop_req <= 1'b1;

      if (!enable || start_set)      xfer_done <= 1'b0;
      else if (end_act == END_DONE)  xfer_done <= 1'b1;

      if (!enable)                     reload_pend <= 1'b0;
      else if (end_act == END_RELOAD)  reload_pend <= 1'b1;
      else if (len_accept)             reload_pend <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_xfer_len_seq.sv
module i2c_xfer_len_seq
  import i2c_len_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             cnt_ctrl_en,
  input  logic             reload_mode,
  input  logic             auto_end,
  input  logic             pec_req,
  input  logic             len_wr,
  input  logic [LEN_W-1:0] len_val,
  input  logic             start_set,
  input  logic             stop_set,
  input  logic             addr_done,
  input  logic             arb_lost,
  input  logic             timeout_err,
  input  logic             stop_det,
  input  logic             byte_done,
  output logic             start_req,
  output logic             stop_req,
  output logic             xfer_done,
  output logic             reload_pend,
  output logic             pec_send,
  output logic [LEN_W-1:0] bytes_left
);
  logic     len_accept;
  logic     seg_end;
  logic     active;
  seg_end_e end_act;

  assign len_accept = len_wr && !start_req;
  assign end_act    = pick_end(seg_end, reload_mode, auto_end);

  i2c_len_counter #(.LEN_W(LEN_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .enable(enable), .ctrl_en(cnt_ctrl_en),
    .addr_done(addr_done), .len_accept(len_accept), .len_val(len_val),
    .byte_done(byte_done), .pend(reload_pend), .end_act(end_act),
    .active(active), .remain(bytes_left), .seg_hit(seg_end)
  );

  i2c_len_flags u_flags (
    .clk(clk), .rst_n(rst_n), .enable(enable), .start_set(start_set),
    .stop_set(stop_set), .addr_done(addr_done), .arb_lost(arb_lost),
    .timeout_err(timeout_err), .stop_det(stop_det), .len_accept(len_accept),
    .end_act(end_act), .start_req(start_req), .stop_req(stop_req),
    .xfer_done(xfer_done), .reload_pend(reload_pend)
  );

  assign pec_send = active && cnt_ctrl_en && !reload_pend && pec_req &&
                    !reload_mode && (bytes_left == LEN_W'(1));
endmodule

// File: rtl/i2c_xfer_len_seq_chk.sv
module i2c_xfer_len_seq_chk #(
  parameter int LEN_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             cnt_ctrl_en,
  input logic             reload_mode,
  input logic             auto_end,
  input logic             len_wr,
  input logic             start_set,
  input logic             addr_done,
  input logic             arb_lost,
  input logic             timeout_err,
  input logic             stop_det,
  input logic             byte_done,
  input logic             start_req,
  input logic             stop_req,
  input logic             xfer_done,
  input logic             reload_pend,
  input logic             pec_send,
  input logic [LEN_W-1:0] bytes_left,
  input logic             seg_end,
  input logic             len_accept
);
  assert_start_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_done || arb_lost || timeout_err) |=> !start_req);

  assert_stop_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !stop_req);

  assert_ignore_wr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (len_wr && start_req && enable && !addr_done && !byte_done) |=> $stable(bytes_left));

  assert_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_end && !reload_mode && !auto_end && !start_set) |=> xfer_done);

  assert_autostop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_end && !reload_mode && auto_end && !stop_det) |=> stop_req);

  assert_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_end && reload_mode) |=> reload_pend);

  assert_pec_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pec_send |-> (!reload_mode && bytes_left == LEN_W'(1)));

  assert_noctrl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_ctrl_en && enable && !addr_done && !len_accept) |=> $stable(bytes_left));

  assert_disable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!start_req && !stop_req && !xfer_done && !reload_pend));
endmodule

bind i2c_xfer_len_seq i2c_xfer_len_seq_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .cnt_ctrl_en(cnt_ctrl_en),
  .reload_mode(reload_mode), .auto_end(auto_end), .len_wr(len_wr),
  .start_set(start_set), .addr_done(addr_done), .arb_lost(arb_lost),
  .timeout_err(timeout_err), .stop_det(stop_det), .byte_done(byte_done),
  .start_req(start_req), .stop_req(stop_req), .xfer_done(xfer_done),
  .reload_pend(reload_pend), .pec_send(pec_send), .bytes_left(bytes_left),
  .seg_end(seg_end), .len_accept(len_accept)
);

// File: tb/i2c_xfer_len_seq_tb.sv
module i2c_xfer_len_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, cnt_ctrl_en = 1'b1, reload_mode = 1'b0, auto_end = 1'b0;
  logic pec_req = 1'b0, len_wr = 1'b0, start_set = 1'b0, stop_set = 1'b0;
  logic addr_done = 1'b0, arb_lost = 1'b0, timeout_err = 1'b0, stop_det = 1'b0;
  logic byte_done = 1'b0;
  logic [7:0] len_val = 8'd0;
  logic start_req, stop_req, xfer_done, reload_pend, pec_send;
  logic [7:0] bytes_left;

  int n_chk = 0, n_bad = 0, cyc = 0;

  // reference model state
  bit m_start, m_stop, m_done, m_pend, m_act;
  int m_cnt, m_len;

  always #10 clk = ~clk;

  i2c_xfer_len_seq u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cnt_ctrl_en(cnt_ctrl_en),
    .reload_mode(reload_mode), .auto_end(auto_end), .pec_req(pec_req),
    .len_wr(len_wr), .len_val(len_val), .start_set(start_set),
    .stop_set(stop_set), .addr_done(addr_done), .arb_lost(arb_lost),
    .timeout_err(timeout_err), .stop_det(stop_det), .byte_done(byte_done),
    .start_req(start_req), .stop_req(stop_req), .xfer_done(xfer_done),
    .reload_pend(reload_pend), .pec_send(pec_send), .bytes_left(bytes_left)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural model, stepped on each rising edge from the previous state.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_start = 0; m_stop = 0; m_done = 0; m_pend = 0; m_act = 0;
      m_cnt = 0; m_len = 0;
    end else begin
      bit acc, counting, hit;
      bit n_start, n_stop, n_done, n_pend, n_act;
      int n_cnt;
      acc = len_wr && !m_start;
      counting = m_act && cnt_ctrl_en && !m_pend;
      hit = enable && counting && ((byte_done && m_cnt == 1) || m_cnt == 0);
      n_act = m_act; n_cnt = m_cnt;
      if (!enable) begin n_act = 0; n_cnt = 0; end
      else if (addr_done) begin n_act = 1; n_cnt = m_len; end
      else if (acc && m_pend) n_cnt = len_val;
      else begin
        if (counting && byte_done && m_cnt > 0) n_cnt = m_cnt - 1;
        if (hit && !reload_mode) n_act = 0;
      end
      n_start = (!enable || addr_done || arb_lost || timeout_err) ? 0 :
                (start_set ? 1 : m_start);
      n_stop = (!enable || stop_det) ? 0 :
               ((stop_set || (hit && !reload_mode && auto_end)) ? 1 : m_stop);
      n_done = (!enable || start_set) ? 0 :
               ((hit && !reload_mode && !auto_end) ? 1 : m_done);
      n_pend = !enable ? 0 : ((hit && reload_mode) ? 1 : (acc ? 0 : m_pend));
      if (acc) m_len = len_val;
      m_start = n_start; m_stop = n_stop; m_done = n_done; m_pend = n_pend;
      m_act = n_act; m_cnt = n_cnt;
    end
  end

  // Every-cycle comparison away from the active edge.
  always @(negedge clk) if (rst_n) begin
    bit exp_pec;
    exp_pec = m_act && cnt_ctrl_en && !m_pend && pec_req && !reload_mode && m_cnt == 1;
    check("R2 start_req", start_req, m_start);
    check("R3/R6 stop_req", stop_req, m_stop);
    check("R5 xfer_done", xfer_done, m_done);
    check("R7 reload_pend", reload_pend, m_pend);
    check("R8 pec_send", pec_send, exp_pec);
    check("R4 bytes_left", bytes_left, m_cnt);
  end

  task automatic tick();
    @(posedge clk); #2;
    len_wr = 0; start_set = 0; stop_set = 0; addr_done = 0; arb_lost = 0;
    timeout_err = 0; stop_det = 0; byte_done = 0;
  endtask

  task automatic write_len(input int v);
    len_wr = 1; len_val = 8'(v); tick();
  endtask

  task automatic begin_xfer();
    start_set = 1; tick();
    addr_done = 1; tick();
  endtask

  task automatic bytes(input int n);
    for (int i = 0; i < n; i++) begin byte_done = 1; tick(); end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
      finish_run();
    end
  end

  initial begin
    #1;
    @(negedge clk);
    // R1: reset state
    check("R1 start_req", start_req, 0); check("R1 stop_req", stop_req, 0);
    check("R1 xfer_done", xfer_done, 0); check("R1 reload_pend", reload_pend, 0);
    check("R1 pec_send", pec_send, 0); check("R1 bytes_left", bytes_left, 0);
    rst_n = 1; enable = 1; tick();

    // R5: plain completion after 3 bytes
    write_len(3); begin_xfer();
    @(negedge clk); check("R4 loaded", bytes_left, 3);
    bytes(3); @(negedge clk); check("R5 done", xfer_done, 1);
    check("R5 no stop", stop_req, 0);

    // R4: write ignored while start_req high
    start_set = 1; tick(); write_len(9); addr_done = 1; tick();
    @(negedge clk); check("R4 ignored write", bytes_left, 3);
    check("R5 cleared by start", xfer_done, 0);
    bytes(3);

    // R6: automatic STOP
    auto_end = 1; write_len(2); begin_xfer(); bytes(2);
    @(negedge clk); check("R6 stop_req", stop_req, 1); check("R6 no done", xfer_done, 0);
    stop_det = 1; tick(); @(negedge clk); check("R3 stop cleared", stop_req, 0);

    // R7: chained reload segments, automatic end ignored
    reload_mode = 1; write_len(2); begin_xfer(); bytes(2);
    @(negedge clk); check("R7 pend", reload_pend, 1); check("R7 no stop", stop_req, 0);
    bytes(2); @(negedge clk); check("R7 holds count", bytes_left, 0);
    write_len(4); @(negedge clk); check("R7 pend cleared", reload_pend, 0);
    check("R7 new count", bytes_left, 4);
    pec_req = 1; bytes(3); @(negedge clk); check("R8 no pec in reload", pec_send, 0);
    bytes(1); @(negedge clk); check("R7 pend again", reload_pend, 1);

    // R8: PEC on last byte, reload off
    reload_mode = 0; auto_end = 0; write_len(3); begin_xfer(); bytes(2);
    @(negedge clk); check("R8 pec_send", pec_send, 1);
    bytes(1); pec_req = 0;

    // R9: zero count
    write_len(0); start_set = 1; tick(); addr_done = 1; tick();
    @(negedge clk); check("R9 not yet", xfer_done, 0);
    tick(); @(negedge clk); check("R9 done", xfer_done, 1);

    // R10: count control disabled
    write_len(3); begin_xfer(); cnt_ctrl_en = 0; bytes(5);
    @(negedge clk); check("R10 frozen", bytes_left, 3); check("R10 no end", xfer_done, 0);
    cnt_ctrl_en = 1;

    // R11: disable clears everything
    stop_set = 1; start_set = 1; tick(); enable = 0; tick();
    @(negedge clk); check("R11 start", start_req, 0); check("R11 stop", stop_req, 0);
    check("R11 count", bytes_left, 0);
    enable = 1; tick();

    // R2: clear wins over set
    start_set = 1; arb_lost = 1; tick(); @(negedge clk); check("R2 clear wins", start_req, 0);

    // random phase under the every-cycle model comparison
    for (int i = 0; i < 20000; i++) begin
      enable = ($urandom_range(0, 199) != 0);
      cnt_ctrl_en = ($urandom_range(0, 29) != 0);
      if ($urandom_range(0, 39) == 0) reload_mode = $urandom_range(0, 1);
      if ($urandom_range(0, 39) == 0) auto_end = $urandom_range(0, 1);
      if ($urandom_range(0, 39) == 0) pec_req = $urandom_range(0, 1);
      len_wr = ($urandom_range(0, 11) == 0); len_val = 8'($urandom_range(0, 5));
      start_set = ($urandom_range(0, 14) == 0);
      stop_set = ($urandom_range(0, 39) == 0);
      addr_done = ($urandom_range(0, 14) == 0);
      arb_lost = ($urandom_range(0, 99) == 0);
      timeout_err = ($urandom_range(0, 99) == 0);
      stop_det = ($urandom_range(0, 19) == 0);
      byte_done = ($urandom_range(0, 2) == 0);
      @(posedge clk); #2;
    end
    tick(); @(negedge clk);
    finish_run();
  end
endmodule